// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block is a direct-mapped cache controller. It sits between a processor request port and a slower main-memory port. The processor issues single-byte reads and writes. Each address is split into three fields: a word offset at the low end, a line index in the middle and a tag at the top. The controller keeps a valid flag, a modified flag and a tag for every line.

A hit is served from the local arrays in one cycle. A write hit changes only the cached copy and marks the line modified. On a miss the controller first empties the line if it holds modified data: the whole old block goes back to memory one byte per beat. It then fetches the whole new block, one byte per beat, and finishes the original request from the refilled line. A write miss allocates the line first and then merges the byte.

The address width, the index width and the offset width are parameters. The address is 24 bits by default. The default index width is small so that the arrays stay modest, and setting it to 14 gives the 14-bit index / 8-bit tag split with 16384 lines.

Top module: `dmc_top`

## Requirements
- R1: An address splits into byte offset `addr[OFF_W-1:0]`, line index `addr[OFF_W+IDX_W-1:OFF_W]` and tag `addr[ADDR_W-1:OFF_W+IDX_W]`. Block number j therefore maps to line j mod 2^IDX_W. Addresses in the same block share a line, different indices never displace each other, and the same index with a different tag replaces the line.
- R2: A request hits only when the indexed line is valid and its stored tag equals the address tag. A read hit raises `cpu_ready` in the first cycle after the request edge, with the addressed byte on `cpu_rdata`, and causes no memory traffic.
- R3: A write hit updates only the cached byte and marks the line modified. It completes in the first cycle after the request edge and issues no memory beat.
- R4: A miss fetches the whole block containing the byte. It uses 2^OFF_W read beats (`mem_we`=0) at offsets 0,1,2,... in order, with the miss address tag and index. After the last beat the requested byte is returned from the refilled line.
- R5: When the victim line is valid and modified, all of its bytes are written to memory (`mem_we`=1) at the victim tag and index, offsets in ascending order. All of these write beats complete before the first refill read beat.
- R6: When the victim line is invalid or unmodified, the miss issues no write beat.
- R7: A write miss allocates. It refills the block, merges the written byte and marks the line modified. Memory is unchanged until that line is later evicted, and the eviction then writes the merged block.
- R8: Synchronous active-high `rst` clears every valid and modified flag and leaves `cpu_ready` and `mem_req` low. After reset every access misses, and a line modified before reset is not written back.
- R9: `cpu_ready` is a single-cycle pulse. While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. A beat completes on the cycle `mem_ack` is seen high.
- R10: A line that has just been refilled is clean. A read miss that displaces it issues no write beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request strobe, sampled while the controller is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_wdata | output | 8 | Byte written on a write-back beat |
| mem_ack | input | 1 | Beat acknowledge, one cycle |
| mem_rdata | input | 8 | Byte returned on a refill beat, valid with `mem_ack` |

## Verification
A hit is due exactly one cycle after the request edge. The bench drives each request at a falling edge and takes the first falling edge after that as cycle one, where it checks `cpu_ready` and `cpu_rdata`. A miss has no fixed latency because the memory model adds a varying delay per beat. For a miss the bench waits for the ready pulse and then checks the counted and logged memory beats (address, direction and global order), the returned byte and the memory image. One more falling edge after each completion confirms that `cpu_ready` has dropped.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_FINISH
    } dmc_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_flags_t;

endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array
    import dmc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    output line_flags_t      look_flags,
    output logic [TAG_W-1:0] look_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx
);

    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= 1'b0;
            end
            if (mark_en) begin
                dirty_q[mark_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    always_comb begin
        look_flags.valid = valid_q[look_idx];
        look_flags.dirty = dirty_q[look_idx];
        look_tag         = tag_q[look_idx];
    end

endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array
    import dmc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int OFF_W = 2
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [IDX_W+OFF_W-1:0] wr_addr,
    input  byte_t                  wr_data,
    input  logic [IDX_W+OFF_W-1:0] rd_addr,
    output byte_t                  rd_data
);

    localparam int CELLS = 1 << (IDX_W + OFF_W);

    byte_t cell_q [CELLS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cell_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  byte_t                  cpu_wdata,
    output logic                   cpu_ready,
    output byte_t                  cpu_rdata,
    output logic [IDX_W-1:0]       look_idx,
    input  line_flags_t            look_flags,
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] look_tag,
    output logic                   fill_en,
    output logic [IDX_W-1:0]       fill_idx,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] fill_tag,
    output logic                   mark_en,
    output logic [IDX_W-1:0]       mark_idx,
    output logic                   dwr_en,
    output logic [IDX_W+OFF_W-1:0] dwr_addr,
    output byte_t                  dwr_data,
    output logic [IDX_W+OFF_W-1:0] drd_addr,
    input  byte_t                  drd_data,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output byte_t                  mem_wdata,
    input  logic                   mem_ack,
    input  byte_t                  mem_rdata,
    output logic                   idle_o
);

    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_fields_t;

    typedef struct packed {
        logic         we;
        addr_fields_t a;
        byte_t        wdata;
    } pending_t;

    dmc_state_e       state_q;
    pending_t         pend_q;
    logic [TAG_W-1:0] victim_tag_q;
    logic [OFF_W-1:0] beat_q;
    logic             ready_q;
    byte_t            rdata_q;

    addr_fields_t     cur;
    logic             in_idle;
    logic             hit;
    logic             last_beat;
    logic             take;

    assign cur       = addr_fields_t'(cpu_addr);
    assign in_idle   = (state_q == ST_IDLE);
    assign take      = in_idle && cpu_req;
    assign look_idx  = in_idle ? cur.idx : pend_q.a.idx;
    assign hit       = look_flags.valid && (look_tag == cur.tag);
    assign last_beat = &beat_q;

    // data array read address
    always_comb begin
        unique case (state_q)
            ST_IDLE:  drd_addr = {cur.idx, cur.off};
            ST_EVICT: drd_addr = {pend_q.a.idx, beat_q};
            default:  drd_addr = {pend_q.a.idx, pend_q.a.off};
        endcase
    end

    // data array write port: cpu hit, refill beat or merge of an allocated write
    always_comb begin
        dwr_en   = 1'b0;
        dwr_addr = {cur.idx, cur.off};
        dwr_data = cpu_wdata;
        if (take && hit && cpu_we) begin
            dwr_en = 1'b1;
        end else if (state_q == ST_FILL && mem_ack) begin
            dwr_en   = 1'b1;
            dwr_addr = {pend_q.a.idx, beat_q};
            dwr_data = mem_rdata;
        end else if (state_q == ST_FINISH && pend_q.we) begin
            dwr_en   = 1'b1;
            dwr_addr = {pend_q.a.idx, pend_q.a.off};
            dwr_data = pend_q.wdata;
        end
    end

    // tag and flag updates
    always_comb begin
        fill_en  = (state_q == ST_FILL) && mem_ack && last_beat;
        fill_idx = pend_q.a.idx;
        fill_tag = pend_q.a.tag;
        mark_en  = (take && hit && cpu_we) || (state_q == ST_FINISH && pend_q.we);
        mark_idx = in_idle ? cur.idx : pend_q.a.idx;
    end

    // memory port
    always_comb begin
        mem_req   = (state_q == ST_EVICT) || (state_q == ST_FILL);
        mem_we    = (state_q == ST_EVICT);
        mem_addr  = (state_q == ST_EVICT) ? {victim_tag_q, pend_q.a.idx, beat_q}
                                          : {pend_q.a.tag, pend_q.a.idx, beat_q};
        mem_wdata = drd_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            pend_q       <= '0;
            victim_tag_q <= '0;
            beat_q       <= '0;
            ready_q      <= 1'b0;
            rdata_q      <= '0;
        end else begin
            ready_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        if (hit) begin
                            if (!cpu_we) begin
                                rdata_q <= drd_data;
                            end
                            ready_q <= 1'b1;
                        end else begin
                            pend_q.we    <= cpu_we;
                            pend_q.a     <= cur;
                            pend_q.wdata <= cpu_wdata;
                            victim_tag_q <= look_tag;
                            beat_q       <= '0;
                            state_q      <= (look_flags.valid && look_flags.dirty)
                                            ? ST_EVICT : ST_FILL;
                        end
                    end
                end
                ST_EVICT: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            state_q <= ST_FINISH;
                        end
                    end
                end
                ST_FINISH: begin
                    if (!pend_q.we) begin
                        rdata_q <= drd_data;
                    end
                    ready_q <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = ready_q;
    assign cpu_rdata = rdata_q;
    assign idle_o    = in_idle;

endmodule

// File: rtl/dmc_top.sv
module dmc_top
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ready,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata
);

    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]       look_idx;
    line_flags_t            look_flags;
    logic [TAG_W-1:0]       look_tag;
    logic                   fill_en;
    logic [IDX_W-1:0]       fill_idx;
    logic [TAG_W-1:0]       fill_tag;
    logic                   mark_en;
    logic [IDX_W-1:0]       mark_idx;
    logic                   dwr_en;
    logic [IDX_W+OFF_W-1:0] dwr_addr;
    byte_t                  dwr_data;
    logic [IDX_W+OFF_W-1:0] drd_addr;
    byte_t                  drd_data;
    logic                   ctrl_idle;

    dmc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
        .clk        (clk),
        .rst        (rst),
        .look_idx   (look_idx),
        .look_flags (look_flags),
        .look_tag   (look_tag),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .mark_en    (mark_en),
        .mark_idx   (mark_idx)
    );

    dmc_data_array #(.IDX_W(IDX_W), .OFF_W(OFF_W)) i_data (
        .clk     (clk),
        .wr_en   (dwr_en),
        .wr_addr (dwr_addr),
        .wr_data (dwr_data),
        .rd_addr (drd_addr),
        .rd_data (drd_data)
    );

    dmc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rdata  (cpu_rdata),
        .look_idx   (look_idx),
        .look_flags (look_flags),
        .look_tag   (look_tag),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .mark_en    (mark_en),
        .mark_idx   (mark_idx),
        .dwr_en     (dwr_en),
        .dwr_addr   (dwr_addr),
        .dwr_data   (dwr_data),
        .drd_addr   (drd_addr),
        .drd_data   (drd_data),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .idle_o     (ctrl_idle)
    );

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cpu_req,
    input logic [ADDR_W-1:0]             cpu_addr,
    input logic                          cpu_ready,
    input logic                          mem_req,
    input logic                          mem_we,
    input logic [ADDR_W-1:0]             mem_addr,
    input logic [7:0]                    mem_wdata,
    input logic                          mem_ack,
    input logic                          st_idle,
    input logic                          lk_valid,
    input logic [ADDR_W-IDX_W-OFF_W-1:0] lk_tag
);

    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    // R2
    hit_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (st_idle && cpu_req && lk_valid && lk_tag == cpu_addr[ADDR_W-1 -: TAG_W])
        |=> cpu_ready);

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));

    // R4
    beat_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_ack && mem_addr[OFF_W-1:0] != {OFF_W{1'b1}})
        |=> (mem_req && mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        st_idle |-> !mem_req);

    // R5
    wb_before_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_we);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!cpu_ready && !mem_req));

endmodule

bind dmc_top dmc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_dmc_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .st_idle   (ctrl_idle),
    .lk_valid  (look_flags.valid),
    .lk_tag    (look_tag)
);

// File: tb/test_dmc_top.sv
`timescale 1ns/1ps
module test_dmc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int total = 0;
    int bad = 0;

    logic [7:0]  bmem   [4096];
    logic [7:0]  shadow [4096];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          seq_no = 0;
    logic [23:0] wr_log [256];
    logic [23:0] rd_log [256];
    int          wr_seq [256];
    int          rd_seq [256];
    int          w_base, r_base;
    logic [7:0]  lfsr = 8'h5b;
    int          wait_cnt = 0;

    always #2 clk = ~clk;

    dmc_top i_dmc_top (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    // memory model: variable delay per beat, one-cycle acknowledge
    initial begin
        forever begin
            @(posedge clk);
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (rst) begin
                mem_ack <= 1'b0;
            end else if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (mem_req) begin
                if (wait_cnt == 0) begin
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        bmem[mem_addr[11:0]]   <= mem_wdata;
                        wr_log[wr_cnt[7:0]]    <= mem_addr;
                        wr_seq[wr_cnt[7:0]]    <= seq_no;
                        wr_cnt                 <= wr_cnt + 1;
                    end else begin
                        mem_rdata              <= bmem[mem_addr[11:0]];
                        rd_log[rd_cnt[7:0]]    <= mem_addr;
                        rd_seq[rd_cnt[7:0]]    <= seq_no;
                        rd_cnt                 <= rd_cnt + 1;
                    end
                    seq_no   <= seq_no + 1;
                    wait_cnt <= int'(lfsr % 3);
                end else begin
                    wait_cnt <= wait_cnt - 1;
                end
            end
        end
    end

    function automatic logic [23:0] mk(input int tag, input int idx, input int off);
        return {tag[15:0], idx[5:0], off[1:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [23:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output int cyc);
        @(negedge clk);
        w_base    = wr_cnt;
        r_base    = rd_cnt;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cpu_req = 1'b0;
            cyc++;
        end while (!cpu_ready && cyc < 400);
        rd = cpu_rdata;
        if (we) shadow[a[11:0]] = wd;
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R9 ready pulse", int'(cpu_ready), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4096; i++) shadow[i] = bmem[i];
    endtask

    task automatic expect_fill(input logic [23:0] a, input string req);
        chk(rd_cnt - r_base == 4, req, rd_cnt - r_base, 4);
        for (int k = 0; k < 4; k++) begin
            chk(rd_log[(r_base + k) % 256] == {a[23:2], k[1:0]}, req,
                int'(rd_log[(r_base + k) % 256]), int'({a[23:2], k[1:0]}));
        end
    endtask

    // R8: reset state
    task automatic t_reset_state();
        chk(cpu_ready == 1'b0, "R8 ready after reset", int'(cpu_ready), 0);
        chk(mem_req == 1'b0, "R8 mem_req after reset", int'(mem_req), 0);
    endtask

    // R4, R1: read miss on an empty line
    task automatic t_read_miss();
        logic [7:0] d; int c;
        logic [23:0] a = mk(1, 3, 2);
        access(1'b0, a, 8'h00, d, c);
        expect_fill(a, "R4 refill beats");
        chk(wr_cnt == w_base, "R6 no write on empty line", wr_cnt - w_base, 0);
        chk(d == shadow[a[11:0]], "R4 miss data", d, shadow[a[11:0]]);
        chk(c > 1, "R4 miss not one cycle", c, 2);
    endtask

    // R2, R1: read hits in the same block
    task automatic t_read_hit();
        logic [7:0] d; int c;
        for (int off = 0; off < 4; off++) begin
            logic [23:0] a = mk(1, 3, off);
            access(1'b0, a, 8'h00, d, c);
            chk(c == 1, "R2 hit latency", c, 1);
            chk(d == shadow[a[11:0]], "R2 hit data", d, shadow[a[11:0]]);
            chk(rd_cnt == r_base && wr_cnt == w_base, "R2 no memory traffic",
                (rd_cnt - r_base) + (wr_cnt - w_base), 0);
        end
    endtask

    // R3: write hit stays in the cache
    task automatic t_write_hit();
        logic [7:0] d; int c;
        logic [23:0] a = mk(1, 3, 1);
        logic [7:0] old = bmem[a[11:0]];
        access(1'b1, a, 8'hA5, d, c);
        chk(c == 1, "R3 write hit latency", c, 1);
        chk(wr_cnt == w_base && rd_cnt == r_base, "R3 no memory traffic",
            (wr_cnt - w_base) + (rd_cnt - r_base), 0);
        chk(bmem[a[11:0]] == old, "R3 memory untouched", bmem[a[11:0]], old);
        access(1'b0, a, 8'h00, d, c);
        chk(c == 1 && d == 8'hA5, "R3 read back", d, 8'hA5);
    endtask

    // R5, R1: conflicting tag on the same index evicts the dirty line first
    task automatic t_dirty_evict();
        logic [7:0] d; int c;
        logic [23:0] a = mk(2, 3, 0);
        access(1'b0, a, 8'h00, d, c);
        chk(wr_cnt - w_base == 4, "R5 write-back beats", wr_cnt - w_base, 4);
        for (int k = 0; k < 4; k++) begin
            chk(wr_log[(w_base + k) % 256] == mk(1, 3, k), "R5 write-back address",
                int'(wr_log[(w_base + k) % 256]), int'(mk(1, 3, k)));
        end
        chk(wr_seq[(w_base + 3) % 256] < rd_seq[r_base % 256], "R5 write-back before refill",
            wr_seq[(w_base + 3) % 256], rd_seq[r_base % 256]);
        chk(bmem[mk(1, 3, 1)] == 8'hA5, "R5 modified byte in memory", bmem[mk(1, 3, 1)], 8'hA5);
        expect_fill(a, "R1 conflict refill");
        chk(d == shadow[a[11:0]], "R1 conflict data", d, shadow[a[11:0]]);
    endtask

    // R6, R10: refilled line is clean, its eviction writes nothing
    task automatic t_clean_evict();
        logic [7:0] d; int c;
        logic [23:0] a = mk(3, 3, 3);
        access(1'b0, a, 8'h00, d, c);
        chk(wr_cnt == w_base, "R10 clean victim no write", wr_cnt - w_base, 0);
        expect_fill(a, "R6 refill");
        chk(d == shadow[a[11:0]], "R6 data", d, shadow[a[11:0]]);
    endtask

    // R7: write miss allocates, merges, and is written back later
    task automatic t_write_miss();
        logic [7:0] d; int c;
        logic [23:0] a = mk(4, 5, 3);
        logic [7:0] old = bmem[a[11:0]];
        access(1'b1, a, 8'h3C, d, c);
        expect_fill(a, "R7 allocate refill");
        chk(wr_cnt == w_base, "R7 no write at allocate", wr_cnt - w_base, 0);
        chk(bmem[a[11:0]] == old, "R7 memory unchanged", bmem[a[11:0]], old);
        access(1'b0, a, 8'h00, d, c);
        chk(c == 1 && d == 8'h3C, "R7 merged byte hit", d, 8'h3C);
        access(1'b0, mk(5, 5, 0), 8'h00, d, c);
        chk(wr_cnt - w_base == 4, "R7 merged block written back", wr_cnt - w_base, 4);
        for (int k = 0; k < 4; k++) begin
            logic [23:0] x = mk(4, 5, k);
            chk(bmem[x[11:0]] == shadow[x[11:0]], "R7 written-back block",
                bmem[x[11:0]], shadow[x[11:0]]);
        end
    endtask

    // R1: different indices do not displace each other
    task automatic t_index_split();
        logic [7:0] d; int c;
        access(1'b0, mk(3, 3, 0), 8'h00, d, c);
        chk(c == 1, "R1 index 3 still held", c, 1);
        access(1'b0, mk(5, 5, 2), 8'h00, d, c);
        chk(c == 1, "R1 index 5 still held", c, 1);
        chk(d == shadow[mk(5, 5, 2)], "R1 data", d, shadow[mk(5, 5, 2)]);
    endtask

    // R8: reset drops valid and modified flags
    task automatic t_reset_clears();
        logic [7:0] d; int c;
        logic [23:0] a = mk(3, 3, 2);
        access(1'b1, a, 8'hE7, d, c);
        chk(c == 1, "R8 setup write hit", c, 1);
        do_reset();
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R8 outputs after reset",
            int'({cpu_ready, mem_req}), 0);
        access(1'b0, a, 8'h00, d, c);
        chk(wr_cnt == w_base, "R8 no write-back after reset", wr_cnt - w_base, 0);
        expect_fill(a, "R8 miss after reset");
        chk(d == bmem[a[11:0]] && d != 8'hE7, "R8 lost modification", d, bmem[a[11:0]]);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            bmem[i]   = 8'(i * 37 + 11);
            shadow[i] = 8'(i * 37 + 11);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_read_miss();
        t_read_hit();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        t_index_split();
        t_reset_clears();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule